// File: doc/BRIEF.md
# Fixed-Off-Time Current Chopper With Decay Selection

This block regulates the current in one H-bridge winding. It turns the bridge on, waits for a blanking interval, and then watches a current-trip comparator. When the trip fires, it turns the bridge off for a programmed fixed off time. During that off time the winding recirculates in slow decay, fast decay, mixed decay (fast first, then slow), or auto-mixed decay. In auto-mixed decay the block decides between fast and slow from the trip level it sees at the end of blanking. When the off time ends, a new cycle begins with the bridge on.

An indexer drives the block with pulses that mark an increase or a decrease of the trip reference. Either pulse ends the current cycle at once. The last direction also selects the decay variant for the two trend-dependent modes. A direct mode lets two pins drive the bridge. The chopper still limits current whenever the pins request drive, and in that mode the trend-dependent modes always behave as for falling current.

All times are counted in 20 ns clock ticks, and one 500 ns unit is 25 ticks. The output is registered and gives one bridge state per cycle.

Top module: `fixed_off_chopper`

## Requirements
- R1: `bridge_state` codes are 0 high-Z, 1 drive forward, 2 drive reverse, 3 fast decay, 4 slow decay. After reset, and in the cycle after `enable` is low or `fault` is high, the output is 0. Raising `enable` starts a fresh cycle with the bridge on.
- R2: With the trip held high, the bridge is on for exactly the blanking time and off for (`toff_code`+1)×25 cycles, and then turns on again. The drive state is 2 when `phase_neg` is 1 and 1 otherwise.
- R3: The blanking time is 50 cycles for `blank_code` up to 50, and `blank_code`+1 cycles above that (256 at 255). The trip is ignored during blanking, so blanking is also the minimum on time.
- R4: When `abt_en` and `ref_low` are both 1, the blanking time is halved (integer division by 2).
- R5: `decay_mode` selects the decay: 0 slow; 1 slow after a rise and mixed after a fall; 2 fast; 3 mixed; 4 slow after a rise and auto-mixed after a fall; 5 auto-mixed; 6 and 7 slow. The trend is set by `ref_dn`, cleared by `ref_up`, and is "rise" after reset.
- R6: Mixed decay is fast for `tdecay_code`×25 cycles and then slow for the rest of the off time. With a code of 0 it is all slow, and if that interval reaches the off time it is all fast.
- R7: In auto-mixed decay, a trip that is high at the end of blanking sends the bridge straight to fast decay. A trip that is low keeps the bridge on until the trip fires, and then it slow-decays for the off time.
- R8: Auto-mixed fast decay ignores the trip for one more blanking time. After that, a low trip moves the bridge to slow decay, and the off time still ends the cycle.
- R9: A `ref_up` pulse restarts the bridge on with a fresh blanking time. A `ref_dn` pulse starts fast decay for a full off time. Either pulse overrides an expiring timer in the same cycle, and `ref_up` wins if both pulses arrive together.
- R10: With `pwm_direct` set, the pins (`pin_a`,`pin_b`) map as follows: 00 gives high-Z, 11 gives slow decay, 10 gives drive forward and 01 gives drive reverse. Reference pulses are ignored in this mode.
- R11: In direct mode with the pins at 10 or 01, the chopper regulates as in R2 to R8, and modes 1 and 4 act as after a fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz tick clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Bridge enable |
| fault | input | 1 | Latched fault for this bridge |
| trip | input | 1 | Current comparator, 1 = at or above trip |
| toff_code | input | 8 | Off time in 500 ns units minus one |
| blank_code | input | 8 | Blanking time code, 20 ns steps |
| abt_en | input | 1 | Adaptive blanking enable |
| tdecay_code | input | 8 | Mixed-decay fast interval in 500 ns units |
| decay_mode | input | 3 | Decay mode select |
| pwm_direct | input | 1 | Direct pin mode |
| pin_a | input | 1 | Direct input, forward side |
| pin_b | input | 1 | Direct input, reverse side |
| ref_up | input | 1 | Pulse: trip reference increased |
| ref_dn | input | 1 | Pulse: trip reference decreased |
| ref_low | input | 1 | Reference below 30% of full scale |
| phase_neg | input | 1 | Winding current sign is negative |
| bridge_state | output | 3 | Registered bridge state |

## Verification
The sharpest collision is a reference pulse that lands in the same cycle as the expiry of the off timer. The bench times a `ref_dn` pulse onto the last off cycle and requires the output to move from slow decay straight to fast decay, with no drive cycle in between. A second collision, `ref_up` and `ref_dn` in the same cycle, must resolve to drive. Run lengths of each output state are measured against bench-computed cycle counts for directed and random settings.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;
  typedef enum logic [2:0] {
    BR_HIZ  = 3'd0,
    BR_FWD  = 3'd1,
    BR_REV  = 3'd2,
    BR_FAST = 3'd3,
    BR_SLOW = 3'd4
  } bridge_e;

  typedef enum logic [1:0] {
    DK_SLOW,
    DK_FAST,
    DK_MIXED,
    DK_AUTO
  } decay_kind_e;

  typedef enum logic [2:0] {
    S_BLANK,
    S_SENSE,
    S_SLOW,
    S_FAST,
    S_MIXF,
    S_AFB,
    S_AFS
  } chop_st_e;
endpackage

// File: rtl/chop_timing.sv
`timescale 1ns/1ps
module chop_timing #(
  parameter int CODE_W      = 8,
  parameter int UNIT_TICKS  = 25,
  parameter int BLANK_FLOOR = 50,
  parameter int CNT_W       = 13
) (
  input  logic [CODE_W-1:0] toff_code,
  input  logic [CODE_W-1:0] blank_code,
  input  logic [CODE_W-1:0] tdecay_code,
  input  logic              abt_en,
  input  logic              ref_low,
  output logic [CNT_W-1:0]  off_ticks,
  output logic [CNT_W-1:0]  blank_ticks,
  output logic [CNT_W-1:0]  decay_ticks
);
  localparam logic [CNT_W-1:0]  UNIT_C  = CNT_W'(UNIT_TICKS);
  localparam logic [CNT_W-1:0]  FLOOR_C = CNT_W'(BLANK_FLOOR);
  localparam logic [CODE_W-1:0] FLOOR_K = CODE_W'(BLANK_FLOOR);

  logic [CNT_W-1:0] blank_full;

  always_comb begin
    off_ticks   = (CNT_W'(toff_code) + CNT_W'(1)) * UNIT_C;
    decay_ticks = CNT_W'(tdecay_code) * UNIT_C;
    blank_full  = (blank_code <= FLOOR_K) ? FLOOR_C
                                          : CNT_W'(blank_code) + CNT_W'(1);
    blank_ticks = (abt_en && ref_low) ? (blank_full >> 1) : blank_full;
  end
endmodule

// File: rtl/chop_decay_sel.sv
`timescale 1ns/1ps
module chop_decay_sel
  import chop_pkg::*;
(
  input  logic [2:0]  decay_mode,
  input  logic        falling,
  output decay_kind_e kind
);
  always_comb begin
    unique case (decay_mode)
      3'd1:    kind = falling ? DK_MIXED : DK_SLOW;
      3'd2:    kind = DK_FAST;
      3'd3:    kind = DK_MIXED;
      3'd4:    kind = falling ? DK_AUTO : DK_SLOW;
      3'd5:    kind = DK_AUTO;
      default: kind = DK_SLOW;
    endcase
  end
endmodule

// File: rtl/chop_fsm.sv
`timescale 1ns/1ps
module chop_fsm
  import chop_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             trip,
  input  logic             ref_up,
  input  logic             ref_dn,
  input  decay_kind_e      kind,
  input  logic [CNT_W-1:0] off_ticks,
  input  logic [CNT_W-1:0] blank_ticks,
  input  logic [CNT_W-1:0] decay_ticks,
  output bridge_e          phase
);
  chop_st_e         st, st_n;
  logic [CNT_W-1:0] ph_cnt, ph_n;
  logic [CNT_W-1:0] off_cnt, off_n;
  logic             in_off;

  function automatic chop_st_e off_entry(decay_kind_e k, logic from_blank, logic dzero);
    unique case (k)
      DK_SLOW:  return S_SLOW;
      DK_FAST:  return S_FAST;
      DK_MIXED: return dzero ? S_SLOW : S_MIXF;
      default:  return from_blank ? S_AFB : S_SLOW;
    endcase
  endfunction

  assign in_off = (st != S_BLANK) && (st != S_SENSE);

  always_comb begin
    st_n  = st;
    ph_n  = ph_cnt;
    off_n = off_cnt;
    if (!run) begin
      st_n  = S_BLANK;
      ph_n  = blank_ticks - CNT_W'(1);
      off_n = off_ticks - CNT_W'(1);
    end else if (ref_up) begin
      st_n = S_BLANK;
      ph_n = blank_ticks - CNT_W'(1);
    end else if (ref_dn) begin
      st_n  = S_FAST;
      off_n = off_ticks - CNT_W'(1);
    end else begin
      unique case (st)
        S_BLANK: begin
          if (ph_cnt != '0) begin
            ph_n = ph_cnt - CNT_W'(1);
          end else if (trip) begin
            st_n  = off_entry(kind, 1'b1, decay_ticks == '0);
            off_n = off_ticks - CNT_W'(1);
            ph_n  = (st_n == S_MIXF) ? decay_ticks - CNT_W'(1)
                                     : blank_ticks - CNT_W'(1);
          end else begin
            st_n = S_SENSE;
          end
        end
        S_SENSE: begin
          if (trip) begin
            st_n  = off_entry(kind, 1'b0, decay_ticks == '0);
            off_n = off_ticks - CNT_W'(1);
            ph_n  = decay_ticks - CNT_W'(1);
          end
        end
        default: begin
          if (off_cnt == '0) begin
            st_n = S_BLANK;
            ph_n = blank_ticks - CNT_W'(1);
          end else begin
            off_n = off_cnt - CNT_W'(1);
            if (st == S_MIXF || st == S_AFB) begin
              if (ph_cnt == '0) st_n = (st == S_MIXF) ? S_SLOW : S_AFS;
              else              ph_n = ph_cnt - CNT_W'(1);
            end else if (st == S_AFS && !trip) begin
              st_n = S_SLOW;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_BLANK;
      ph_cnt  <= '0;
      off_cnt <= '0;
    end else begin
      st      <= st_n;
      ph_cnt  <= ph_n;
      off_cnt <= off_n;
    end
  end

  always_comb begin
    unique case (st)
      S_BLANK, S_SENSE: phase = BR_FWD;
      S_SLOW:           phase = BR_SLOW;
      default:          phase = BR_FAST;
    endcase
  end

  AST_MIN_ON: assert property (@(posedge clk) disable iff (rst)
    (run && !ref_up && !ref_dn && st == S_BLANK && ph_cnt != '0) |=> (st == S_BLANK)); // R3
  AST_OFF_END: assert property (@(posedge clk) disable iff (rst)
    (run && !ref_up && !ref_dn && in_off && off_cnt == '0) |=> (st == S_BLANK)); // R2
  AST_SECOND_BLANK: assert property (@(posedge clk) disable iff (rst)
    (run && !ref_up && !ref_dn && st == S_AFB && ph_cnt != '0 && off_cnt != '0) |=> (st == S_AFB)); // R8
  AST_REF_UP: assert property (@(posedge clk) disable iff (rst)
    (run && ref_up) |=> (st == S_BLANK)); // R9
  AST_REF_DN: assert property (@(posedge clk) disable iff (rst)
    (run && ref_dn && !ref_up) |=> (st == S_FAST)); // R9
endmodule

// File: rtl/fixed_off_chopper.sv
`timescale 1ns/1ps
module fixed_off_chopper
  import chop_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int UNIT_TICKS  = 25,
  parameter int BLANK_FLOOR = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              fault,
  input  logic              trip,
  input  logic [CODE_W-1:0] toff_code,
  input  logic [CODE_W-1:0] blank_code,
  input  logic              abt_en,
  input  logic [CODE_W-1:0] tdecay_code,
  input  logic [2:0]        decay_mode,
  input  logic              pwm_direct,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              ref_up,
  input  logic              ref_dn,
  input  logic              ref_low,
  input  logic              phase_neg,
  output logic [2:0]        bridge_state
);
  localparam int CNT_W = $clog2((1 << CODE_W) * UNIT_TICKS + 1);

  logic [CNT_W-1:0] off_ticks, blank_ticks, decay_ticks;
  logic             falling_q, falling_eff, run, up_g, dn_g, live;
  decay_kind_e      kind;
  bridge_e          phase, drive_st, out_n, out_q;

  assign up_g        = ref_up && !pwm_direct;
  assign dn_g        = ref_dn && !pwm_direct;
  assign falling_eff = falling_q || pwm_direct;
  assign live        = enable && !fault;
  assign run         = live && (pwm_direct ? (pin_a ^ pin_b) : 1'b1);

  always_ff @(posedge clk) begin
    if (rst)       falling_q <= 1'b0;
    else if (up_g) falling_q <= 1'b0;
    else if (dn_g) falling_q <= 1'b1;
  end

  chop_timing #(
    .CODE_W(CODE_W), .UNIT_TICKS(UNIT_TICKS),
    .BLANK_FLOOR(BLANK_FLOOR), .CNT_W(CNT_W)
  ) u_timing (
    .toff_code(toff_code), .blank_code(blank_code), .tdecay_code(tdecay_code),
    .abt_en(abt_en), .ref_low(ref_low),
    .off_ticks(off_ticks), .blank_ticks(blank_ticks), .decay_ticks(decay_ticks)
  );

  chop_decay_sel u_sel (
    .decay_mode(decay_mode), .falling(falling_eff), .kind(kind)
  );

  chop_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .run(run), .trip(trip),
    .ref_up(up_g), .ref_dn(dn_g), .kind(kind),
    .off_ticks(off_ticks), .blank_ticks(blank_ticks), .decay_ticks(decay_ticks),
    .phase(phase)
  );

  always_comb begin
    if (pwm_direct) drive_st = pin_a ? BR_FWD : BR_REV;
    else            drive_st = phase_neg ? BR_REV : BR_FWD;

    if (!live)                           out_n = BR_HIZ;
    else if (pwm_direct && !pin_a && !pin_b) out_n = BR_HIZ;
    else if (pwm_direct && pin_a && pin_b)   out_n = BR_SLOW;
    else if (phase == BR_FWD)            out_n = drive_st;
    else                                 out_n = phase;
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= BR_HIZ;
    else     out_q <= out_n;
  end

  assign bridge_state = out_q;

  AST_FORCE_HIZ: assert property (@(posedge clk) disable iff (rst)
    (!enable || fault) |=> (bridge_state == 3'd0)); // R1
  AST_DIRECT_SLOW: assert property (@(posedge clk) disable iff (rst)
    (enable && !fault && pwm_direct && pin_a && pin_b) |=> (bridge_state == 3'd4)); // R10
  AST_DIRECT_HIZ: assert property (@(posedge clk) disable iff (rst)
    (enable && !fault && pwm_direct && !pin_a && !pin_b) |=> (bridge_state == 3'd0)); // R10
endmodule

// File: tb/fixed_off_chopper_bench.sv
`timescale 1ns/1ps
module fixed_off_chopper_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 0, fault = 0, trip = 0, abt_en = 0, pwm_direct = 0;
  logic pin_a = 1, pin_b = 0, ref_up = 0, ref_dn = 0, ref_low = 0, phase_neg = 0;
  logic [7:0] toff_code = 0, blank_code = 0, tdecay_code = 0;
  logic [2:0] decay_mode = 0;
  logic [2:0] bridge_state;

  int tests = 0;
  int fails = 0;

  localparam logic [2:0] HIZ = 3'd0, FWD = 3'd1, REV = 3'd2, FST = 3'd3, SLW = 3'd4;

  always #4 clk = ~clk;

  fixed_off_chopper u_fixed_off_chopper (
    .clk(clk), .rst(rst), .enable(enable), .fault(fault), .trip(trip),
    .toff_code(toff_code), .blank_code(blank_code), .abt_en(abt_en),
    .tdecay_code(tdecay_code), .decay_mode(decay_mode), .pwm_direct(pwm_direct),
    .pin_a(pin_a), .pin_b(pin_b), .ref_up(ref_up), .ref_dn(ref_dn),
    .ref_low(ref_low), .phase_neg(phase_neg), .bridge_state(bridge_state)
  );

  function automatic int exp_blank(int code, bit abt, bit low);
    int b;
    b = (code <= 50) ? 50 : code + 1;
    if (abt && low) b = b / 2;
    return b;
  endfunction

  function automatic int exp_off(int code);
    return (code + 1) * 25;
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_enter(logic [2:0] s);
    logic [2:0] prev;
    prev = bridge_state;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (bridge_state == s && prev != s) return;
      prev = bridge_state;
    end
  endtask

  task automatic run_len(output int n, output logic [2:0] s);
    s = bridge_state;
    n = 0;
    while (bridge_state == s && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic setup(int mode, int toff, int blank, int td, bit abt, bit low, bit dir, bit tr);
    enable = 0;
    @(negedge clk);
    @(negedge clk);
    decay_mode = 3'(mode); toff_code = 8'(toff); blank_code = 8'(blank);
    tdecay_code = 8'(td); abt_en = abt; ref_low = low; pwm_direct = dir; trip = tr;
    @(negedge clk);
    enable = 1;
  endtask

  // mode kind with trend: 0 slow, 1 fast, 2 mixed, 3 auto
  function automatic int kind_of(int mode, bit falling);
    case (mode)
      1: return falling ? 2 : 0;
      2: return 1;
      3: return 2;
      4: return falling ? 3 : 0;
      5: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic check_pattern(string tag, int mode, bit falling, int b, int off, int td, logic [2:0] drv);
    int n; logic [2:0] s; int k;
    k = kind_of(mode, falling);
    wait_enter(drv);
    run_len(n, s);
    chk({tag, " drive state"}, s, drv);
    chk({tag, " drive length"}, n, b);
    run_len(n, s);
    if (k == 0 || (k == 2 && td == 0)) begin
      chk({tag, " slow state"}, s, SLW); chk({tag, " slow length"}, n, off);
    end else if (k == 1 || k == 3 || (k == 2 && td >= off)) begin
      chk({tag, " fast state"}, s, FST); chk({tag, " fast length"}, n, off);
    end else begin
      chk({tag, " fast state"}, s, FST); chk({tag, " fast length"}, n, td);
      run_len(n, s);
      chk({tag, " slow state"}, s, SLW); chk({tag, " slow length"}, n, off - td);
    end
    chk({tag, " back to drive"}, bridge_state, drv);
  endtask

  task automatic pulse(bit up, bit dn);
    ref_up = up; ref_dn = dn;
    @(negedge clk);
    ref_up = 0; ref_dn = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n; logic [2:0] s;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset state", bridge_state, HIZ);

    setup(0, 3, 10, 0, 0, 0, 0, 1);
    check_pattern("R2 R3 slow floor", 0, 0, 50, 100, 0, FWD);
    setup(2, 5, 8'h80, 0, 0, 0, 0, 1);
    check_pattern("R3 fast blank 0x80", 2, 0, 129, 150, 0, FWD);
    setup(0, 1, 8'hFF, 0, 1, 1, 0, 1);
    check_pattern("R4 abt halved", 0, 0, 128, 50, 0, FWD);
    setup(0, 1, 8'hFF, 0, 1, 0, 0, 1);
    check_pattern("R4 abt not low", 0, 0, 256, 50, 0, FWD);

    phase_neg = 1;
    setup(0, 3, 10, 0, 0, 0, 0, 1);
    check_pattern("R2 reverse polarity", 0, 0, 50, 100, 0, REV);
    phase_neg = 0;

    setup(3, 9, 10, 4, 0, 0, 0, 1);
    check_pattern("R6 mixed split", 3, 0, 50, 250, 100, FWD);
    setup(3, 9, 10, 0, 0, 0, 0, 1);
    check_pattern("R6 mixed zero", 3, 0, 50, 250, 0, FWD);
    setup(3, 3, 10, 20, 0, 0, 0, 1);
    check_pattern("R6 mixed long", 3, 0, 50, 100, 500, FWD);

    pulse(0, 1);
    setup(1, 9, 10, 4, 0, 0, 0, 1);
    check_pattern("R5 mode1 falling", 1, 1, 50, 250, 100, FWD);
    pulse(1, 0);
    setup(1, 9, 10, 4, 0, 0, 0, 1);
    check_pattern("R5 mode1 rising", 1, 0, 50, 250, 100, FWD);
    setup(6, 3, 10, 4, 0, 0, 0, 1);
    check_pattern("R5 reserved slow", 6, 0, 50, 100, 100, FWD);

    setup(5, 5, 10, 0, 0, 0, 0, 1);
    check_pattern("R7 auto trip high", 5, 0, 50, 150, 0, FWD);
    setup(5, 5, 10, 0, 0, 0, 0, 0);
    repeat (80) @(negedge clk);
    chk("R7 auto held on", bridge_state, FWD);
    trip = 1;
    repeat (3) @(negedge clk);
    chk("R7 auto slow after trip", bridge_state, SLW);

    setup(5, 40, 10, 0, 0, 0, 0, 1);
    wait_enter(FST);
    repeat (3) @(negedge clk);
    trip = 0;
    repeat (50 - 8) @(negedge clk);
    chk("R8 trip ignored in second blank", bridge_state, FST);
    repeat (10) @(negedge clk);
    chk("R8 slow after second blank", bridge_state, SLW);

    setup(0, 40, 10, 0, 0, 0, 0, 1);
    wait_enter(SLW);
    repeat (10) @(negedge clk);
    pulse(1, 0);
    @(negedge clk);
    chk("R9 ref_up drives", bridge_state, FWD);
    pulse(0, 1);
    wait_enter(FST);
    run_len(n, s);
    chk("R9 ref_dn fast length", n, exp_off(40));
    wait_enter(SLW);
    pulse(1, 1);
    @(negedge clk);
    chk("R9 both pulses drive", bridge_state, FWD);

    // R9 collision: ref_dn on the last off cycle
    setup(0, 3, 10, 0, 0, 0, 0, 1);
    wait_enter(SLW);
    repeat (100 - 2) @(negedge clk);
    ref_dn = 1;
    @(negedge clk);
    ref_dn = 0;
    chk("R9 collision still slow", bridge_state, SLW);
    @(negedge clk);
    chk("R9 collision goes fast", bridge_state, FST);

    setup(0, 3, 10, 0, 0, 0, 1, 0);
    pin_a = 0; pin_b = 0; repeat (2) @(negedge clk);
    chk("R10 pins 00", bridge_state, HIZ);
    pin_a = 1; pin_b = 1; repeat (2) @(negedge clk);
    chk("R10 pins 11", bridge_state, SLW);
    pin_a = 1; pin_b = 0; repeat (2) @(negedge clk);
    chk("R10 pins 10", bridge_state, FWD);
    pin_a = 0; pin_b = 1; repeat (2) @(negedge clk);
    chk("R10 pins 01", bridge_state, REV);
    pin_a = 1; pin_b = 0;

    pulse(1, 0);
    setup(1, 9, 10, 4, 0, 0, 1, 1);
    check_pattern("R11 direct mixed", 1, 1, 50, 250, 100, FWD);
    pwm_direct = 0;

    setup(0, 3, 10, 0, 0, 0, 0, 1);
    repeat (20) @(negedge clk);
    fault = 1; repeat (2) @(negedge clk);
    chk("R1 fault high-Z", bridge_state, HIZ);
    fault = 0; enable = 0; repeat (2) @(negedge clk);
    chk("R1 disable high-Z", bridge_state, HIZ);

    for (int it = 0; it < 20; it++) begin
      int modes[6] = '{0, 2, 3, 5, 6, 7};
      int m, tf, bc, td; bit ab, lw;
      m = modes[$urandom % 6]; tf = $urandom % 24; bc = $urandom % 256;
      td = $urandom % 24; ab = 1'($urandom % 2); lw = 1'($urandom % 2);
      setup(m, tf, bc, td, ab, lw, 0, 1);
      check_pattern("R2 R5 random", m, 0, exp_blank(bc, ab, lw), exp_off(tf), td * 25, FWD);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule